// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the faster module clock. A 13-bit control word holds two divisor fields and a law-select bit. In linear mode the serial period is 2×(n+1) module cycles. In power-of-two mode the period is 2^m module cycles. Software picks the law and the divisor; the block only counts.

At every half-period the block raises a one-cycle toggle strobe. The shift logic launches data on one strobe and samples on the next. The block also drives a registered clock level that flips after each strobe. While the run input is low, the counter rests at zero, no strobe is raised and the level holds the idle polarity input.

The divider samples a new control word only while idle or on a strobe edge. A half-period that is already under way always finishes with the length it started with, so the clock never produces a runt phase.

Top module: `spi_clkdiv`

## Requirements
- R1: With bit 12 of the control word set (linear law), the half-period is n+1 module cycles, where n is bits 7:0. The serial period is therefore 2×(n+1).
- R2: With bit 12 clear (power-of-two law) and m = bits 11:8 nonzero, the half-period is 2^(m-1) module cycles. The serial period is therefore 2^m.
- R3: The field the law does not use has no effect on timing. Bits 11:8 are ignored in linear mode, and bits 7:0 are ignored in power-of-two mode.
- R4: With the power-of-two law and m = 0, the strobe is high on every running cycle and the level flips every cycle. This is the fastest setting, half the module clock; the serial clock is never faster than that.
- R5: A control word changed while running takes effect only after the next strobe. The half-period in progress completes with its original length.
- R6: While run is low, the strobe stays low and the level equals idle polarity one cycle later. Under reset, the strobe is low and the level is 0.
- R7: While running, the level inverts on the clock edge that ends a strobe cycle and changes at no other edge.
- R8: When run rises, counting restarts from zero. The first strobe comes in running cycle H-1, counting the first running cycle as 0, where H is the half-period. The same is true after run is dropped in mid-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Divider enable; low holds the divider idle |
| idlePol | input | 1 | Clock level driven while idle |
| ctrlWord | input | 13 | [7:0] linear divisor n, [11:8] exponent m, [12] law select (1 = linear) |
| sclkToggle | output | 1 | One-cycle strobe at each half-period boundary |
| sclkLevel | output | 1 | Divided serial clock level |

## Verification
The embedded assertions check, on every cycle, that a strobe appears only while running and that the level changes only after a strobe. They also check that the idle level follows idle polarity, that the count stays inside the active half-period, and that the latched configuration cannot change between strobes. Only the bench scenarios can show the actual half-period length for each law and divisor. The same holds for ignoring the unused field, for the deferred effect of a mid-run reconfiguration, and for the restart from zero after run toggles.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  // Strobes passed from the counting control to the level datapath.
  typedef struct packed {
    logic toggle;  // half-period boundary this cycle
    logic hold;    // divider idle, force idle polarity
  } clkStrobe_t;
endpackage

// File: rtl/spi_clkdiv_ctrl.sv
module spi_clkdiv_ctrl
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     run,
  input  logic [LIN_W+EXP_W:0]     ctrlWord,
  output clkStrobe_t               strobes
);
  localparam int CW_W    = LIN_W + EXP_W + 1;
  localparam int SEL_BIT = LIN_W + EXP_W;
  localparam int POW_MAX = (1 << EXP_W) - 1;
  localparam int CNT_W   = (POW_MAX > LIN_W + 1) ? POW_MAX : LIN_W + 1;

  logic [CW_W-1:0]  cfgQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLen;
  logic [EXP_W-1:0] expF;
  logic             toggle;

  assign expF = cfgQ[SEL_BIT-1:LIN_W];

  // Half-period length in module cycles for the latched law.
  always_comb begin
    if (cfgQ[SEL_BIT]) begin
      halfLen = CNT_W'(cfgQ[LIN_W-1:0]) + CNT_W'(1);
    end else if (expF == '0) begin
      halfLen = CNT_W'(1);
    end else begin
      halfLen = CNT_W'(1) << (expF - EXP_W'(1));
    end
  end

  assign toggle = run && (cnt == halfLen - CNT_W'(1));

  // New configuration is accepted only while idle or at a boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (!run || toggle) begin
      cfgQ <= ctrlWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run || toggle) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign strobes.toggle = toggle;
  assign strobes.hold   = !run;

  // R6: no strobe while idle
  assert_strobe_needs_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toggle |-> run);

  // R5: configuration frozen between boundaries while running
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && !$past(toggle)) |-> $stable(cfgQ));

  // R8: count never leaves the active half-period
  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt < halfLen);

  // R8: idle cycle returns counter to zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!run) |-> (cnt == '0));
endmodule

// File: rtl/spi_clkdiv_dp.sv
module spi_clkdiv_dp
  import spi_clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       idlePol,
  input  clkStrobe_t strobes,
  output logic       level
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= 1'b0;
    end else if (strobes.hold) begin
      level <= idlePol;
    end else if (strobes.toggle) begin
      level <= ~level;
    end
  end

  // R6: idle level follows idle polarity
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.hold) |-> (level == $past(idlePol)));

  // R7: while running, level changes exactly after a strobe
  assert_level_on_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobes.hold)) |-> ((level != $past(level)) == $past(strobes.toggle)));
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_clkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 idlePol,
  input  logic [LIN_W+EXP_W:0] ctrlWord,
  output logic                 sclkToggle,
  output logic                 sclkLevel
);
  clkStrobe_t strobes;

  spi_clkdiv_ctrl #(.LIN_W(LIN_W), .EXP_W(EXP_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  spi_clkdiv_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .idlePol (idlePol),
    .strobes (strobes),
    .level   (sclkLevel)
  );

  assign sclkToggle = strobes.toggle;
endmodule

// File: tb/spi_clkdiv_tb_top.sv
module spi_clkdiv_tb_top;
  localparam int NV    = 12;
  localparam int LIMIT = 20000;

  // linear: {1, m, n}; power-of-two: {0, m, n}
  localparam logic [12:0] VEC_CTRL [NV] = '{
    {1'b1, 4'd0, 8'd0},   {1'b1, 4'd0, 8'd3},   {1'b1, 4'd0, 8'd255},
    {1'b1, 4'd7, 8'd2},   {1'b0, 4'd0, 8'd0},   {1'b0, 4'd1, 8'd0},
    {1'b0, 4'd2, 8'd0},   {1'b0, 4'd5, 8'd0},   {1'b0, 4'd9, 8'd0},
    {1'b0, 4'd3, 8'd200}, {1'b0, 4'd15, 8'd0},  {1'b1, 4'd0, 8'd99}
  };
  localparam int VEC_HALF [NV] = '{1, 4, 256, 3, 1, 1, 2, 16, 256, 4, 16384, 100};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic idlePol = 1'b0;
  logic [12:0] ctrlWord = '0;
  logic sclkToggle;
  logic sclkLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  spi_clkdiv dut_i (
    .clk(clk), .rstN(rstN), .run(run), .idlePol(idlePol),
    .ctrlWord(ctrlWord), .sclkToggle(sclkToggle), .sclkLevel(sclkLevel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count running cycles until the strobe is seen, starting just after a negedge.
  task automatic waitStrobe(output int cycles);
    cycles = 0;
    #1;
    while (!sclkToggle && cycles < LIMIT) begin
      @(negedge clk);
      #1;
      cycles++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int c;
    int lv;
    // R6: reset state
    #5;
    check(sclkToggle == 1'b0, "R6 reset strobe", sclkToggle, 0);
    check(sclkLevel == 1'b0, "R6 reset level", sclkLevel, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R6: idle with fastest config, no strobe, level follows idlePol
    ctrlWord = {1'b0, 4'd0, 8'd0};
    idlePol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(sclkToggle == 1'b0, "R6 idle strobe", sclkToggle, 0);
    check(sclkLevel == 1'b1, "R6 idle level", sclkLevel, 1);
    idlePol = 1'b0;

    // Table walk: R1 linear, R2 power-of-two, R3 unused field, R7 level, R8 restart
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run = 1'b0;
      ctrlWord = VEC_CTRL[i];
      @(negedge clk);
      @(negedge clk);
      #1;
      check(sclkLevel == 1'b0, "R6 level before run", sclkLevel, 0);
      run = 1'b1;
      waitStrobe(c);
      if (VEC_CTRL[i][12])
        check(c == VEC_HALF[i] - 1, "R1/R3/R8 first half", c, VEC_HALF[i] - 1);
      else
        check(c == VEC_HALF[i] - 1, "R2/R3/R8 first half", c, VEC_HALF[i] - 1);
      @(negedge clk);
      #1;
      check(sclkLevel == 1'b1, "R7 level after strobe", sclkLevel, 1);
      waitStrobe(c);
      if (VEC_CTRL[i][12])
        check(c == VEC_HALF[i] - 1, "R1 second half", c, VEC_HALF[i] - 1);
      else
        check(c == VEC_HALF[i] - 1, "R2 second half", c, VEC_HALF[i] - 1);
      @(negedge clk);
      #1;
      check(sclkLevel == 1'b0, "R7 level after second strobe", sclkLevel, 0);
      run = 1'b0;
    end

    // R4: m = 0, strobe every running cycle, level flips every cycle
    @(negedge clk);
    ctrlWord = {1'b0, 4'd0, 8'd0};
    @(negedge clk);
    run = 1'b1;
    #1;
    lv = sclkLevel;
    for (int k = 0; k < 6; k++) begin
      check(sclkToggle == 1'b1, "R4 strobe each cycle", sclkToggle, 1);
      @(negedge clk);
      #1;
      check(sclkLevel != lv[0], "R4 level flips", sclkLevel, !lv[0]);
      lv = sclkLevel;
    end
    run = 1'b0;

    // R5: change control word mid half-period
    @(negedge clk);
    ctrlWord = {1'b1, 4'd0, 8'd3};
    @(negedge clk);
    run = 1'b1;
    waitStrobe(c);
    check(c == 3, "R5 initial half", c, 3);
    @(negedge clk);
    @(negedge clk);
    ctrlWord = {1'b1, 4'd0, 8'd0};
    waitStrobe(c);
    check(c == 2, "R5 old half kept", c, 2);
    @(negedge clk);
    waitStrobe(c);
    check(c == 0, "R5 new half applied", c, 0);
    @(negedge clk);
    run = 1'b0;

    // R8: drop run mid-count, restart from zero
    ctrlWord = {1'b0, 4'd4, 8'd0};
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    #1;
    check(sclkToggle == 1'b0, "R6 strobe gone when idle", sclkToggle, 0);
    @(negedge clk);
    run = 1'b1;
    waitStrobe(c);
    check(c == 7, "R8 restart from zero", c, 7);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule